// File: doc/BRIEF.md
# Phase-Shifted Inverted-Sine Carrier Modulator

This block produces the switch commands for one leg of a nine-level clamped converter. A signed reference sample is compared against eight carriers. Each carrier has an inverted-sine shape and covers the whole signed range. All eight carriers run at one frequency. They differ only in phase, and successive carriers are spaced by half a turn divided by the carrier count, which is 22.5° for eight carriers. One phase accumulator advances by a programmable increment on each enabled cycle, and every carrier phase is derived from it.

Each comparator bit is set while the reference lies strictly above its carrier. The number of set bits is the output level, from 0 to 8. The level then drives a complementary gate pattern: the upper switch of pair k conducts when k is at most the level, and its lower partner always takes the opposite state. The reference can be a plain sine. It can also be a sine with a min-max offset added, which gives the flat-topped variant. The bench uses a 0.8 index sine as one of its stimuli.

Top module: `ps_isine_pwm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase accumulator is cleared to 0, `cmp_o` and `level_o` become 0, `gate_hi_o` becomes all zeros and `gate_lo_o` becomes all ones.
- R2: On each rising edge with `en` high and `rst` low, the master phase becomes (phase + `step_in`) mod 65536. Wrap-around is silent.
- R3: Carrier k (k = 0..7) uses the phase x = (master phase + k·4096) mod 65536. The value 4096 is 22.5° in 16-bit phase units.
- R4: The value of carrier k is 32768 − 4·floor(x·(65536 − x) / 65536). This value is +32768 at x = 0 and −32768 at x = 32768.
- R5: On an enabled edge, bit k of `cmp_o` is loaded with 1 when the signed `ref_in` is strictly greater than carrier k. The carrier value used is the one from the master phase held before that edge.
- R6: `level_o` equals the number of set bits among the eight comparator results loaded at the same edge.
- R7: Bit k−1 of `gate_hi_o` is 1 exactly when k ≤ `level_o`, for k = 1..8. The upper gates therefore form a thermometer code from bit 0 upward.
- R8: `gate_lo_o` is always the bitwise inverse of `gate_hi_o`.
- R9: On an edge with `en` low and `rst` low, the phase and all outputs keep their values, whatever `ref_in` and `step_in` are.
- R10: A reference of −32768 clears every comparator bit. A reference of +32767 sets bit k unless carrier k is at or above +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the block |
| ref_in | input | 16 | Signed reference sample |
| step_in | input | 16 | Phase increment per enabled cycle |
| cmp_o | output | 8 | Registered comparator bits, one per carrier |
| level_o | output | 4 | Registered output level 0..8 |
| gate_hi_o | output | 8 | Upper switch commands, thermometer coded |
| gate_lo_o | output | 8 | Complementary lower switch commands |

## Verification
Two things can fall in the same clock. The master accumulator can wrap, while the offset carriers cross the reference and are compared against the phase value from before that wrap. The bench provokes this with an increment of 0xFFFF and with increments near a quarter turn, under a ramp reference and a sine reference. A second collision is an enable drop or a reset that lands mid-run while the comparator bits are changing. A behavioural model computes every carrier from its formula, and all four outputs are compared with it on every clock. This shows whether the design used the pre-wrap phase, and whether it held or cleared in the right cycle.

// File: rtl/ps_pwm_pkg.sv
package ps_pwm_pkg;
  localparam int unsigned CARRIERS_DEF = 8;
  localparam int unsigned PHASE_W_DEF  = 16;
  localparam int unsigned REF_W_DEF    = 16;

  // phase spacing between successive carriers: half a turn split evenly
  function automatic int unsigned carrier_spacing(input int unsigned phase_w,
                                                  input int unsigned n);
    return (2 ** phase_w) / (2 * n);
  endfunction
endpackage

// File: rtl/ps_phase_acc.sv
module ps_phase_acc #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_q + step;
    end
  end

  assign phase = acc_q;
endmodule

// File: rtl/ps_isine_carrier.sv
module ps_isine_carrier #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned REF_W   = 16,
  parameter int unsigned OFFSET  = 0
) (
  input  logic [PHASE_W-1:0]    phase,
  output logic signed [REF_W:0] carrier
);
  localparam int unsigned SH = PHASE_W - REF_W;
  localparam logic [PHASE_W-1:0] OFF = PHASE_W'(OFFSET);
  localparam logic [REF_W:0] HALF = (REF_W+1)'(2 ** (REF_W - 1));

  logic [PHASE_W-1:0]   x;
  logic [PHASE_W:0]     xw;
  logic [PHASE_W:0]     inv;
  logic [2*PHASE_W:0]   prod;
  logic [PHASE_W:0]     s;
  logic [REF_W:0]       scaled;

  always_comb begin
    x      = phase + OFF;
    xw     = {1'b0, x};
    inv    = (PHASE_W+1)'(2 ** PHASE_W) - xw;
    // parabolic half-sine: peaks at a quarter of full scale mid-turn
    prod   = {{PHASE_W{1'b0}}, xw} * {{PHASE_W{1'b0}}, inv};
    s      = (PHASE_W+1)'(prod >> PHASE_W);
    scaled = (REF_W+1)'((s >> SH) << 2);
    carrier = $signed(HALF - scaled);
  end
endmodule

// File: rtl/ps_level_enc.sv
module ps_level_enc #(
  parameter int unsigned NCAR  = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic [NCAR-1:0]  bits,
  output logic [LVL_W-1:0] level,
  output logic [NCAR-1:0]  gates
);
  always_comb begin
    level = '0;
    for (int i = 0; i < NCAR; i++) begin
      level = level + LVL_W'(bits[i]);
    end
  end

  for (genvar g = 0; g < NCAR; g++) begin : g_thermo
    assign gates[g] = (level >= LVL_W'(g + 1));
  end
endmodule

// File: rtl/ps_isine_pwm.sv
module ps_isine_pwm
  import ps_pwm_pkg::*;
#(
  parameter int unsigned NCAR    = CARRIERS_DEF,
  parameter int unsigned PHASE_W = PHASE_W_DEF,
  parameter int unsigned REF_W   = REF_W_DEF,
  localparam int unsigned LVL_W  = $clog2(NCAR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [REF_W-1:0]   ref_in,
  input  logic [PHASE_W-1:0] step_in,
  output logic [NCAR-1:0]    cmp_o,
  output logic [LVL_W-1:0]   level_o,
  output logic [NCAR-1:0]    gate_hi_o,
  output logic [NCAR-1:0]    gate_lo_o
);
  localparam int unsigned SPACING = carrier_spacing(PHASE_W, NCAR);

  logic [PHASE_W-1:0]    phase;
  logic signed [REF_W:0] ref_x;
  logic [NCAR-1:0]       cmp_d;
  logic [LVL_W-1:0]      level_d;
  logic [NCAR-1:0]       gates_d;

  ps_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .step  (step_in),
    .phase (phase)
  );

  assign ref_x = $signed({ref_in[REF_W-1], ref_in});

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic signed [REF_W:0] car;
    ps_isine_carrier #(
      .PHASE_W (PHASE_W),
      .REF_W   (REF_W),
      .OFFSET  (k * SPACING)
    ) u_car (
      .phase   (phase),
      .carrier (car)
    );
    assign cmp_d[k] = (ref_x > car);
  end

  ps_level_enc #(.NCAR(NCAR), .LVL_W(LVL_W)) u_enc (
    .bits  (cmp_d),
    .level (level_d),
    .gates (gates_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_o     <= '0;
      level_o   <= '0;
      gate_hi_o <= '0;
      gate_lo_o <= '1;
    end else if (en) begin
      cmp_o     <= cmp_d;
      level_o   <= level_d;
      gate_hi_o <= gates_d;
      gate_lo_o <= ~gates_d;
    end
  end
endmodule

// File: rtl/ps_isine_pwm_chk.sv
module ps_isine_pwm_chk #(
  parameter int unsigned NCAR  = 8,
  parameter int unsigned REF_W = 16,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [REF_W-1:0] ref_in,
  input logic [NCAR-1:0]  cmp_o,
  input logic [LVL_W-1:0] level_o,
  input logic [NCAR-1:0]  gate_hi_o,
  input logic [NCAR-1:0]  gate_lo_o
);
  localparam logic [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level_o == '0 && cmp_o == '0 && gate_lo_o == '1)); // R1

  AST_LEVEL_IS_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(cmp_o) == int'(level_o)); // R6

  AST_GATE_THERMO: assert property (@(posedge clk) disable iff (rst)
    (((gate_hi_o + 1'b1) & gate_hi_o) == '0) &&
    ($countones(gate_hi_o) == int'(level_o))); // R7

  AST_GATE_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    gate_lo_o == ~gate_hi_o); // R8

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cmp_o) && $stable(level_o) && $stable(gate_hi_o))); // R9

  AST_MIN_REF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en && ref_in == REF_MIN) |=> (cmp_o == '0)); // R10
endmodule

bind ps_isine_pwm ps_isine_pwm_chk #(
  .NCAR  (NCAR),
  .REF_W (REF_W),
  .LVL_W (LVL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .ref_in    (ref_in),
  .cmp_o     (cmp_o),
  .level_o   (level_o),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o)
);

// File: tb/ps_isine_pwm_bench.sv
`timescale 1ns/1ps
module ps_isine_pwm_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] ref_in = '0;
  logic [15:0] step_in = '0;
  logic [7:0]  cmp_o;
  logic [3:0]  level_o;
  logic [7:0]  gate_hi_o;
  logic [7:0]  gate_lo_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  longint m_phase = 0;
  int     e_cmp = 0;
  int     e_lvl = 0;
  int     e_hi = 0;
  int     e_lo = 255;
  string  tag = "R1";

  always #5 clk = ~clk;

  ps_isine_pwm u_ps_isine_pwm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ref_in    (ref_in),
    .step_in   (step_in),
    .cmp_o     (cmp_o),
    .level_o   (level_o),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o)
  );

  function automatic longint car_val(longint ph, int k);
    longint x = (ph + k * 4096) % 65536;
    longint s = (x * (65536 - x)) / 65536;
    return 32768 - 4 * s;
  endfunction

  task automatic check(string t, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // model: update what the outputs become at the coming edge
  task automatic model_edge(bit r, bit e, int rv, int sv);
    if (r) begin
      m_phase = 0; e_cmp = 0; e_lvl = 0; e_hi = 0; e_lo = 255;
    end else if (e) begin
      longint refs = (rv >= 32768) ? rv - 65536 : rv;
      e_cmp = 0; e_lvl = 0;
      for (int k = 0; k < 8; k++) begin
        if (refs > car_val(m_phase, k)) begin
          e_cmp |= (1 << k);
          e_lvl++;
        end
      end
      e_hi = 0;
      for (int k = 1; k <= 8; k++) if (k <= e_lvl) e_hi |= (1 << (k - 1));
      e_lo = (~e_hi) & 255;
      m_phase = (m_phase + sv) % 65536;
    end
  endtask

  task automatic cyc(bit r, bit e, int rv, int sv);
    rst = r; en = e; ref_in = 16'(rv); step_in = 16'(sv);
    @(posedge clk);
    model_edge(r, e, rv, sv);
    @(negedge clk);
    check({tag, " cmp R5"}, int'(cmp_o), e_cmp);
    check({tag, " level R6"}, int'(level_o), e_lvl);
    check({tag, " gates R7"}, int'(gate_hi_o), e_hi);
    check({tag, " complement R8"}, int'(gate_lo_o), e_lo);
  endtask

  function automatic int sine_ref(int n, int period);
    real v = 26214.0 * $sin(6.283185307 * real'(n) / real'(period));
    int iv = int'(v);
    return iv & 16'hFFFF;
  endfunction

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 0, 16'h1234, 500);
    tag = "R2 R3 R4";
    for (int i = 0; i < 60; i++) cyc(0, 1, 0, 1000);
    for (int i = 0; i < 1500; i++) cyc(0, 1, sine_ref(i, 417), 2731);
    tag = "R2 wrap";
    for (int i = 0; i < 200; i++) cyc(0, 1, (i * 331) & 16'hFFFF, 16'hFFFF);
    for (int i = 0; i < 100; i++) cyc(0, 1, sine_ref(i, 37), 16'h3FFF + (i % 3));
    tag = "R10 max";
    for (int i = 0; i < 80; i++) cyc(0, 1, 16'h7FFF, 1111);
    tag = "R10 min";
    for (int i = 0; i < 80; i++) cyc(0, 1, 16'h8000, 1111);
    tag = "R9";
    for (int i = 0; i < 300; i++)
      cyc(0, (i % 4) < 2, sine_ref(i, 113), 777 + i);
    tag = "R1 midrun";
    cyc(1, 1, 16'h6000, 4000);
    cyc(1, 1, 16'h6000, 4000);
    tag = "R2 R3 R4 after reset";
    for (int i = 0; i < 150; i++) cyc(0, 1, sine_ref(i, 150), 3000);
    finish_run();
  end
endmodule